// File: doc/BRIEF.md
# Card Power-State Controller

This block sequences the pads of an SD/MMC card slot through its power states. A two-bit power field, written over a simple register port, selects one of three states. In the power-cycle state every card signal pad is driven low, so the card cannot draw current through its signal lines. In the power-off state the controller is disabled and the pads are driven high. In the power-on state the card clock generator is enabled and the clock pad carries the generated clock.

After entry to power-on, the command and data pads stay driven high and take no part in traffic until a fixed number of card clock cycles has passed (74 by default). The block counts strobes from the card clock generator to measure this window. Once the count is reached it raises an interface-ready flag and hands the command and data pads over to the host core's own output-enable and output values. A direction-polarity bit and two voltage-switch bits share the same register. They are passed straight out as configuration levels for the external level shifter and supply logic.

Top module: `card_pwr_ctrl`

## Requirements
- R1: After reset the power field is 00 (off), the three configuration outputs are 0, card_clk_en and if_ready are 0, and every pad is driven (oe=1) high (out=1).
- R2: A write with wr_en high and addr equal to 0 loads the register: bits [1:0] are the power field (00 off, 10 cycle, 11 on), bit 2 is voltage-switch, bit 3 is voltage-switch enable and bit 4 is direction polarity. A write to any other address changes nothing.
- R3: A write of the reserved power value 01 leaves the power state unchanged, while bits 2 to 4 of the same write still take effect.
- R4: In power-cycle, the clock, command and all data pads are driven (oe=1) low (out=0), and card_clk_en is 0.
- R5: In power-off, the clock, command and all data pads are driven (oe=1) high (out=1), and card_clk_en and if_ready are 0.
- R6: In power-on, card_clk_en is 1 and the clock pad is driven with core_ck. Until if_ready is set, the command and data pads are driven high.
- R7: In power-on, each cycle with card_clk_tick high advances a wake-up count. if_ready rises in the cycle after the 74th such tick. Ticks seen outside power-on are not counted.
- R8: While if_ready is 1, the command and data pad oe/out follow core_cmd_oe/core_cmd_out and core_dat_oe/core_dat_out bit for bit.
- R9: Leaving power-on drops if_ready in the same cycle as the write and clears the count, so a later return to power-on waits the full 74 ticks again.
- R10: A read with rd_en high and addr 0 returns, in the next cycle on rdata, the power field and configuration bits at the positions of R2 with all other bits 0. Any other cycle gives rdata of 0.
- R11: dir_pol, vsw and vsw_en continuously show register bits 4, 2 and 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Register address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data, valid the cycle after rd_en |
| card_clk_tick | input | 1 | One-cycle strobe per card clock period |
| core_ck | input | 1 | Generated card clock from the clock divider |
| core_cmd_oe | input | 1 | Host core command output enable |
| core_cmd_out | input | 1 | Host core command output value |
| core_dat_oe | input | DAT_W | Host core data output enables |
| core_dat_out | input | DAT_W | Host core data output values |
| card_clk_en | output | 1 | Enable for the card clock generator |
| if_ready | output | 1 | Wake-up window complete, interface live |
| ck_oe | output | 1 | Clock pad output enable |
| ck_out | output | 1 | Clock pad output value |
| cmd_oe | output | 1 | Command pad output enable |
| cmd_out | output | 1 | Command pad output value |
| dat_oe | output | DAT_W | Data pad output enables |
| dat_out | output | DAT_W | Data pad output values |
| dir_pol | output | 1 | Direction polarity configuration |
| vsw | output | 1 | Voltage-switch configuration |
| vsw_en | output | 1 | Voltage-switch enable configuration |

## Verification
Some properties are checked on every cycle. The reserved power value never appears as a state. The wake-up count never passes its limit, holds when no tick arrives and is zero after any non-on cycle. if_ready only occurs in power-on, and the pad levels match the cycle and off states. Other behaviours need the bench's scenarios and its reference model. These are the exact cycle on which if_ready rises after the 74th tick, the discarding of ticks seen in power-cycle, the restart of the window after power-off, the handover of random core pad values after the window, and the read-back latency.

// File: rtl/cpc_pkg.sv
package cpc_pkg;
   typedef enum logic [1:0] {
      PS_OFF   = 2'b00,
      PS_RSVD  = 2'b01,
      PS_CYCLE = 2'b10,
      PS_ON    = 2'b11
   } pstate_e;

   typedef struct packed {
      logic dir_pol;
      logic vsw_en;
      logic vsw;
   } pcfg_t;

   localparam int unsigned FLD_PWR_LO = 0;
   localparam int unsigned FLD_VSW    = 2;
   localparam int unsigned FLD_VSWEN  = 3;
   localparam int unsigned FLD_DIRPOL = 4;
   localparam int unsigned FLD_TOP    = 4;
endpackage

// File: rtl/cpc_regs.sv
module cpc_regs
   import cpc_pkg::*;
#(
   parameter int unsigned ADDR_W  = 8,
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned REG_OFS = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output pstate_e           state,
   output pcfg_t             cfg,
   output logic [DATA_W-1:0] rdata
);
   localparam logic [ADDR_W-1:0] OFS = ADDR_W'(REG_OFS);

   if (DATA_W <= FLD_TOP) begin : g_bad_dw
      $error("cpc_regs: DATA_W too small for the register fields");
   end
   if (REG_OFS >= (1 << ADDR_W)) begin : g_bad_ofs
      $error("cpc_regs: REG_OFS does not fit in ADDR_W");
   end

   logic              hit;
   logic [DATA_W-1:0] rb;
   logic              unused_hi;

   assign hit       = (addr == OFS);
   assign unused_hi = ^wdata[DATA_W-1:FLD_TOP+1];

   always_comb begin
      rb                          = '0;
      rb[FLD_PWR_LO+1:FLD_PWR_LO] = state;
      rb[FLD_VSW]                 = cfg.vsw;
      rb[FLD_VSWEN]               = cfg.vsw_en;
      rb[FLD_DIRPOL]              = cfg.dir_pol;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= PS_OFF;
         cfg   <= '0;
         rdata <= '0;
      end else begin
         if (wr_en && hit) begin
            cfg.vsw     <= wdata[FLD_VSW];
            cfg.vsw_en  <= wdata[FLD_VSWEN];
            cfg.dir_pol <= wdata[FLD_DIRPOL];
            if (wdata[FLD_PWR_LO+1:FLD_PWR_LO] != PS_RSVD)
               state <= pstate_e'(wdata[FLD_PWR_LO+1:FLD_PWR_LO]);
         end
         rdata <= (rd_en && hit) ? rb : '0;
      end
   end

   AST_NO_RSVD_STATE: assert property (@(posedge clk) disable iff (!rst_n)
      state != PS_RSVD); // R3
   AST_RSVD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && hit && wdata[FLD_PWR_LO+1:FLD_PWR_LO] == PS_RSVD) |=> $stable(state)); // R3
   AST_MISS_NOWRITE: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && hit) |=> ($stable(state) && $stable(cfg))); // R2
   AST_RD_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_en && hit) |=> (rdata == '0)); // R10
endmodule

// File: rtl/cpc_wakeup.sv
module cpc_wakeup
   import cpc_pkg::*;
#(
   parameter int unsigned READY_CNT = 74
) (
   input  logic    clk,
   input  logic    rst_n,
   input  pstate_e state,
   input  logic    tick,
   output logic    ready
);
   localparam int unsigned CNT_W = $clog2(READY_CNT + 1);
   localparam logic [CNT_W-1:0] LIMIT = CNT_W'(READY_CNT);

   if (READY_CNT < 1) begin : g_bad_cnt
      $error("cpc_wakeup: READY_CNT must be at least 1");
   end

   logic [CNT_W-1:0] cnt;
   logic             in_on;

   assign in_on = (state == PS_ON);
   assign ready = in_on && (cnt == LIMIT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (!in_on)
         cnt <= '0;
      else if (tick && (cnt != LIMIT))
         cnt <= cnt + 1'b1;
   end

   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= LIMIT); // R7
   AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (in_on && !tick) |=> $stable(cnt)); // R7
   AST_CLR_LEAVE: assert property (@(posedge clk) disable iff (!rst_n)
      !in_on |=> (cnt == '0)); // R9
   AST_READY_ONLY_ON: assert property (@(posedge clk) disable iff (!rst_n)
      ready |-> in_on); // R9
endmodule

// File: rtl/cpc_pads.sv
module cpc_pads
   import cpc_pkg::*;
#(
   parameter int unsigned DAT_W = 8
) (
   input  pstate_e          state,
   input  logic             ready,
   input  logic             core_ck,
   input  logic             core_cmd_oe,
   input  logic             core_cmd_out,
   input  logic [DAT_W-1:0] core_dat_oe,
   input  logic [DAT_W-1:0] core_dat_out,
   output logic             card_clk_en,
   output logic             ck_oe,
   output logic             ck_out,
   output logic             cmd_oe,
   output logic             cmd_out,
   output logic [DAT_W-1:0] dat_oe,
   output logic [DAT_W-1:0] dat_out
);
   if (DAT_W != 1 && DAT_W != 4 && DAT_W != 8) begin : g_bad_dat
      $error("cpc_pads: DAT_W must be 1, 4 or 8");
   end

   logic live;
   logic idle_lvl;

   assign card_clk_en = (state == PS_ON);
   assign live        = card_clk_en && ready;
   // off and reserved drive high, cycle drives low, on idles high until live
   assign idle_lvl    = (state != PS_CYCLE);

   always_comb begin
      ck_oe  = 1'b1;
      ck_out = card_clk_en ? core_ck : idle_lvl;
   end

   always_comb begin
      cmd_oe  = live ? core_cmd_oe  : 1'b1;
      cmd_out = live ? core_cmd_out : idle_lvl;
   end

   for (genvar i = 0; i < DAT_W; i++) begin : g_dat
      always_comb begin
         dat_oe[i]  = live ? core_dat_oe[i]  : 1'b1;
         dat_out[i] = live ? core_dat_out[i] : idle_lvl;
      end
   end
endmodule

// File: rtl/card_pwr_ctrl.sv
module card_pwr_ctrl
   import cpc_pkg::*;
#(
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned REG_OFS   = 0,
   parameter int unsigned DAT_W     = 8,
   parameter int unsigned READY_CNT = 74
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   input  logic              card_clk_tick,
   input  logic              core_ck,
   input  logic              core_cmd_oe,
   input  logic              core_cmd_out,
   input  logic [DAT_W-1:0]  core_dat_oe,
   input  logic [DAT_W-1:0]  core_dat_out,
   output logic              card_clk_en,
   output logic              if_ready,
   output logic              ck_oe,
   output logic              ck_out,
   output logic              cmd_oe,
   output logic              cmd_out,
   output logic [DAT_W-1:0]  dat_oe,
   output logic [DAT_W-1:0]  dat_out,
   output logic              dir_pol,
   output logic              vsw,
   output logic              vsw_en
);
   pstate_e state;
   pcfg_t   cfg;

   cpc_regs #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .REG_OFS(REG_OFS)
   ) u_regs (
      .clk  (clk),
      .rst_n(rst_n),
      .wr_en(wr_en),
      .rd_en(rd_en),
      .addr (addr),
      .wdata(wdata),
      .state(state),
      .cfg  (cfg),
      .rdata(rdata)
   );

   cpc_wakeup #(
      .READY_CNT(READY_CNT)
   ) u_wake (
      .clk  (clk),
      .rst_n(rst_n),
      .state(state),
      .tick (card_clk_tick),
      .ready(if_ready)
   );

   cpc_pads #(
      .DAT_W(DAT_W)
   ) u_pads (
      .state       (state),
      .ready       (if_ready),
      .core_ck     (core_ck),
      .core_cmd_oe (core_cmd_oe),
      .core_cmd_out(core_cmd_out),
      .core_dat_oe (core_dat_oe),
      .core_dat_out(core_dat_out),
      .card_clk_en (card_clk_en),
      .ck_oe       (ck_oe),
      .ck_out      (ck_out),
      .cmd_oe      (cmd_oe),
      .cmd_out     (cmd_out),
      .dat_oe      (dat_oe),
      .dat_out     (dat_out)
   );

   assign dir_pol = cfg.dir_pol;
   assign vsw     = cfg.vsw;
   assign vsw_en  = cfg.vsw_en;

   AST_CYCLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (state == PS_CYCLE) |-> (ck_oe && cmd_oe && (&dat_oe) && !ck_out && !cmd_out
                               && (dat_out == '0) && !card_clk_en)); // R4
   AST_OFF_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (state == PS_OFF) |-> (ck_oe && cmd_oe && (&dat_oe) && ck_out && cmd_out
                             && (&dat_out) && !card_clk_en && !if_ready)); // R5
   AST_READY_NEEDS_CLK: assert property (@(posedge clk) disable iff (!rst_n)
      if_ready |-> card_clk_en); // R6
   AST_PREREADY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (card_clk_en && !if_ready) |-> (cmd_oe && cmd_out && (&dat_oe) && (&dat_out))); // R6
endmodule

// File: tb/sim_card_pwr_ctrl.sv
`timescale 1ns/1ps
module sim_card_pwr_ctrl;
   localparam int DW = 8;
   localparam int LIM = 74;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0, rd_en = 1'b0;
   logic [7:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        card_clk_tick = 1'b0;
   logic        core_ck = 1'b0, core_cmd_oe = 1'b0, core_cmd_out = 1'b0;
   logic [DW-1:0] core_dat_oe = '0, core_dat_out = '0;
   logic        card_clk_en, if_ready, ck_oe, ck_out, cmd_oe, cmd_out;
   logic [DW-1:0] dat_oe, dat_out;
   logic        dir_pol, vsw, vsw_en;

   int n_chk = 0, n_fail = 0;
   bit done = 0;

   always #10 clk = ~clk;

   card_pwr_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .card_clk_tick(card_clk_tick),
      .core_ck(core_ck), .core_cmd_oe(core_cmd_oe), .core_cmd_out(core_cmd_out),
      .core_dat_oe(core_dat_oe), .core_dat_out(core_dat_out),
      .card_clk_en(card_clk_en), .if_ready(if_ready), .ck_oe(ck_oe),
      .ck_out(ck_out), .cmd_oe(cmd_oe), .cmd_out(cmd_out), .dat_oe(dat_oe),
      .dat_out(dat_out), .dir_pol(dir_pol), .vsw(vsw), .vsw_en(vsw_en)
   );

   // behavioural reference model
   logic [1:0]  m_state;
   int          m_cnt;
   logic [2:0]  m_cfg;   // {dir_pol, vsw_en, vsw}
   logic [31:0] m_rdata;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_state <= 2'b00; m_cnt <= 0; m_cfg <= 3'b000; m_rdata <= '0;
      end else begin
         if (wr_en && addr == 8'h00) begin
            m_cfg <= {wdata[4], wdata[3], wdata[2]};
            if (wdata[1:0] != 2'b01) m_state <= wdata[1:0];
         end
         if (m_state != 2'b11) m_cnt <= 0;
         else if (card_clk_tick && m_cnt < LIM) m_cnt <= m_cnt + 1;
         m_rdata <= (rd_en && addr == 8'h00) ? {27'd0, m_cfg[2], m_cfg[1], m_cfg[0], m_state} : 32'd0;
      end
   end

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic [19:0] exp_pads();
      logic r;
      logic [19:0] p;
      r = (m_state == 2'b11) && (m_cnt == LIM);
      case (m_state)
         2'b10:   p = {1'b1, 1'b0, 1'b1, 1'b0, {DW{1'b1}}, {DW{1'b0}}};
         2'b11:   p = r ? {1'b1, core_ck, core_cmd_oe, core_cmd_out, core_dat_oe, core_dat_out}
                        : {1'b1, core_ck, 1'b1, 1'b1, {DW{1'b1}}, {DW{1'b1}}};
         default: p = {1'b1, 1'b1, 1'b1, 1'b1, {DW{1'b1}}, {DW{1'b1}}};
      endcase
      return p;
   endfunction

   // per-cycle comparison, away from the clock edge
   always @(posedge clk) begin
      #2;
      if (!done) begin : cmp
         logic [19:0] ap, ep;
         logic er;
         string lbl;
         ap = {ck_oe, ck_out, cmd_oe, cmd_out, dat_oe, dat_out};
         ep = exp_pads();
         er = (m_state == 2'b11) && (m_cnt == LIM);
         if (!rst_n) lbl = "R1";
         else if (m_state == 2'b10) lbl = "R4";
         else if (m_state == 2'b11) lbl = er ? "R8" : "R6";
         else lbl = "R5";
         chk(ap === ep, lbl, 64'(ap), 64'(ep));
         chk(if_ready === er, "R7 if_ready", 64'(if_ready), 64'(er));
         chk(card_clk_en === (m_state == 2'b11), "R6 card_clk_en", 64'(card_clk_en), 64'(m_state == 2'b11));
         chk(rdata === m_rdata, "R10 rdata", 64'(rdata), 64'(m_rdata));
         chk({dir_pol, vsw_en, vsw} === m_cfg, "R11 cfg", 64'({dir_pol, vsw_en, vsw}), 64'(m_cfg));
      end
   end

   // random core pad activity
   always @(negedge clk) begin
      core_ck      <= ~core_ck;
      core_cmd_oe  <= 1'($urandom);
      core_cmd_out <= 1'($urandom);
      core_dat_oe  <= DW'($urandom);
      core_dat_out <= DW'($urandom);
   end

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk); wr_en = 1'b0; addr = '0; wdata = '0;
   endtask

   task automatic rd_expect(input logic [31:0] exp, input string req);
      @(negedge clk); rd_en = 1'b1; addr = 8'h00;
      @(negedge clk); rd_en = 1'b0;
      #1 chk(rdata === exp, req, 64'(rdata), 64'(exp));
   endtask

   task automatic ticks(input int n, input int gap);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); card_clk_tick = 1'b1;
         @(negedge clk); card_clk_tick = 1'b0;
         for (int j = 0; j < gap; j++) @(negedge clk);
      end
   endtask

   task automatic finish_run();
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      #(20 * 200000);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=hung expected=done");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      #1 chk({ck_out, cmd_out, dat_out, card_clk_en, if_ready} === {1'b1, 1'b1, {DW{1'b1}}, 2'b00},
             "R1 reset pads", 64'({ck_out, cmd_out, dat_out, card_clk_en, if_ready}),
             64'({1'b1, 1'b1, {DW{1'b1}}, 2'b00}));
      rst_n = 1'b1;
      rd_expect(32'h0, "R1 reset read");

      // power-cycle, ticks here must not count
      wr(8'h00, 32'h2);
      rd_expect(32'h2, "R2 read cycle");
      #1 chk({ck_out, cmd_out, dat_out} === '0, "R4 pads low", 64'({ck_out, cmd_out, dat_out}), 64'd0);
      ticks(20, 0);

      // power-on, window of LIM ticks with gaps
      wr(8'h00, 32'h3);
      ticks(LIM - 1, 1);
      #1 chk(if_ready === 1'b0, "R7 before last tick", 64'(if_ready), 64'd0);
      ticks(1, 0);
      #1 chk(if_ready === 1'b1, "R7 after last tick", 64'(if_ready), 64'd1);
      repeat (20) @(negedge clk);
      ticks(5, 0);

      // reserved value keeps state, other bits land
      wr(8'h00, 32'h15);
      #1 chk(if_ready === 1'b1, "R3 state kept", 64'(if_ready), 64'd1);
      #1 chk({dir_pol, vsw_en, vsw} === 3'b101, "R3 cfg written", 64'({dir_pol, vsw_en, vsw}), 64'h5);
      rd_expect(32'h17, "R3 read");

      // other offset ignored
      wr(8'h04, 32'h0);
      #1 chk(if_ready === 1'b1, "R2 other offset ignored", 64'(if_ready), 64'd1);
      wr(8'h04, 32'h1C);
      rd_expect(32'h17, "R2 other offset no cfg");

      // leave power-on, return, window restarts
      wr(8'h00, 32'h8);
      #1 chk(if_ready === 1'b0, "R9 ready drops", 64'(if_ready), 64'd0);
      #1 chk(vsw_en === 1'b1, "R11 vsw_en", 64'(vsw_en), 64'd1);
      ticks(3, 0);
      wr(8'h00, 32'h3);
      ticks(LIM - 1, 0);
      #1 chk(if_ready === 1'b0, "R9 full window again", 64'(if_ready), 64'd0);
      ticks(1, 2);
      #1 chk(if_ready === 1'b1, "R9 ready after restart", 64'(if_ready), 64'd1);
      repeat (30) @(negedge clk);

      // cycle then off
      wr(8'h00, 32'h2);
      repeat (5) @(negedge clk);
      wr(8'h00, 32'h0);
      #1 chk({ck_out, cmd_out, dat_out} === {(DW+2){1'b1}}, "R5 pads high",
             64'({ck_out, cmd_out, dat_out}), 64'({(DW+2){1'b1}}));
      repeat (5) @(negedge clk);
      finish_run();
   end
endmodule